// File: doc/BRIEF.md
# Segment Selection and Linear Address Generator

This block keeps the six segment registers of a segmented address space: one code segment, one stack segment and four data segments. Each register is a 16-bit selector paired with a 32-bit base. For every memory access the core presents an access kind and a 32-bit offset. The block picks the segment that the kind implies, adds the offset to that segment's base and registers the resulting linear address. It also reports which segment it used and that segment's selector.

Instruction fetches always go through the code segment, and the core's instruction pointer is the offset. Stack accesses always go through the stack segment. Data accesses use the primary data segment unless an override code names another segment. Software-style loads may write the stack segment and the four data segments. The code segment can only be rewritten through a separate far-transfer port, which the core drives on far jumps, far calls, interrupts and exceptions. A load aimed at the code segment is refused and flagged.

Descriptor lookup, limit checks and privilege checks are done elsewhere. The base arrives together with the selector.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, `addr_valid` and `ld_err` are low. Reset clears every selector and base to zero, so an access made before any load returns its offset unchanged, with selector 0.
- R2: An access sampled on a clock edge produces `addr_lin` = base + offset, modulo 2^32, one cycle later, with `addr_valid` high in that cycle. After a cycle with no access, `addr_valid` is low.
- R3: An access of kind 0 (instruction fetch) uses segment code 0, the code segment, whatever the override inputs say.
- R4: An access of kind 1 (stack) uses segment code 1, the stack segment, whatever the override inputs say.
- R5: An access of kind 2 or 3 (data) works as follows:
  - with `acc_ovr_en` low, it uses segment code 2, the primary data segment;
  - with `acc_ovr_en` high and `acc_ovr_seg` in 0..5, it uses that segment;
  - override codes 6 and 7 fall back to segment code 2.
  - The segment codes are 0 code, 1 stack, 2 primary data, 3, 4 and 5 the further data segments.
- R6: A load with `ld_seg` in 1..5 writes that segment's selector and base. Accesses issued on the following cycle or later see the new values. An access issued in the same cycle as the load still sees the old values.
- R7: A load with `ld_seg` equal to 0, 6 or 7 changes no register. It raises `ld_err` for exactly the following cycle. A load with `ld_seg` in 1..5 leaves `ld_err` low in the following cycle.
- R8: A far transfer writes the code segment's selector and base, with the same next-cycle timing as R6.
- R9: In the cycle `addr_valid` is high, `addr_seg` gives the code of the segment used and `addr_sel` gives that segment's selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Explicit segment load request |
| ld_seg | input | 3 | Target segment code of the load |
| ld_sel | input | 16 | Selector to load |
| ld_base | input | 32 | Base to load |
| far_valid | input | 1 | Far-transfer update of the code segment |
| far_sel | input | 16 | New code-segment selector |
| far_base | input | 32 | New code-segment base |
| acc_valid | input | 1 | Access request |
| acc_kind | input | 2 | 0 fetch, 1 stack, 2 or 3 data |
| acc_ovr_en | input | 1 | Data-segment override enable |
| acc_ovr_seg | input | 3 | Override segment code |
| acc_offset | input | 32 | Offset, or instruction pointer for fetches |
| addr_valid | output | 1 | Linear address valid |
| addr_lin | output | 32 | Linear address |
| addr_seg | output | 3 | Segment code used |
| addr_sel | output | 16 | Selector of the segment used |
| ld_err | output | 1 | Previous-cycle load was refused |

## Verification
The bench uses one segment whose base lies near the top of the address space. An adder that kept a carry beyond 32 bits, or that truncated wrongly, would give a wrong address there. It issues an access in the same cycle as a load, and in the same cycle as a far transfer. Logic that bypassed the write would show the new base one access too early; logic that delayed it would show it one access too late. It sends override codes on fetch and stack accesses, where a design that obeyed them would report the wrong segment. It also sends the undefined override codes 6 and 7 on data accesses, where a design could index past the register array. Finally it tries to load the code segment and the unused code 6. A design that accepted either would show a changed code-segment base on the next fetch, or would miss the error pulse.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int NUM_SEG = 6;
  localparam int SEL_W   = 16;
  localparam int ADDR_W  = 32;
  localparam int SEG_W   = $clog2(NUM_SEG);

  localparam int CS_IDX  = 0;
  localparam int SS_IDX  = 1;
  localparam int DS_IDX  = 2;

  typedef enum logic [1:0] {
    ACC_FETCH    = 2'd0,
    ACC_STACK    = 2'd1,
    ACC_DATA     = 2'd2,
    ACC_DATA_ALT = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/seg_bank.sv
module seg_bank
  import seg_pkg::*;
#(
  parameter int N   = NUM_SEG,
  parameter int SW  = SEL_W,
  parameter int AW  = ADDR_W,
  parameter int CW  = SEG_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_valid,
  input  logic [CW-1:0]         ld_seg,
  input  logic [SW-1:0]         ld_sel,
  input  logic [AW-1:0]         ld_base,
  input  logic                  far_valid,
  input  logic [SW-1:0]         far_sel,
  input  logic [AW-1:0]         far_base,
  output logic [N-1:0][SW-1:0]  sel_q,
  output logic [N-1:0][AW-1:0]  base_q,
  output logic                  ld_err
);
  localparam logic [CW-1:0] CS_CODE = CW'(CS_IDX);
  localparam logic [CW-1:0] N_CODE  = CW'(N);

  // A load is refused when it names the code segment or no segment at all.
  logic ld_bad;
  assign ld_bad = ld_valid && ((ld_seg == CS_CODE) || (ld_seg >= N_CODE));

  always_ff @(posedge clk) begin
    if (rst) ld_err <= 1'b0;
    else     ld_err <= ld_bad;
  end

  for (genvar i = 0; i < N; i++) begin : g_seg
    logic          wr_en;
    logic [SW-1:0] wr_sel;
    logic [AW-1:0] wr_base;

    if (i == CS_IDX) begin : g_code
      // The code segment is written only by far transfers.
      assign wr_en   = far_valid;
      assign wr_sel  = far_sel;
      assign wr_base = far_base;
    end else begin : g_loadable
      assign wr_en   = ld_valid && (ld_seg == CW'(i));
      assign wr_sel  = ld_sel;
      assign wr_base = ld_base;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q[i]  <= '0;
        base_q[i] <= '0;
      end else if (wr_en) begin
        sel_q[i]  <= wr_sel;
        base_q[i] <= wr_base;
      end
    end
  end
endmodule

// File: rtl/seg_route.sv
module seg_route
  import seg_pkg::*;
#(
  parameter int N   = NUM_SEG,
  parameter int SW  = SEL_W,
  parameter int AW  = ADDR_W,
  parameter int CW  = SEG_W
) (
  input  logic [1:0]            acc_kind,
  input  logic                  acc_ovr_en,
  input  logic [CW-1:0]         acc_ovr_seg,
  input  logic [N-1:0][SW-1:0]  sel_q,
  input  logic [N-1:0][AW-1:0]  base_q,
  output logic [CW-1:0]         seg_id,
  output logic [SW-1:0]         seg_sel,
  output logic [AW-1:0]         seg_base
);
  localparam logic [CW-1:0] CS_CODE = CW'(CS_IDX);
  localparam logic [CW-1:0] SS_CODE = CW'(SS_IDX);
  localparam logic [CW-1:0] DS_CODE = CW'(DS_IDX);
  localparam logic [CW-1:0] N_CODE  = CW'(N);

  logic ovr_ok;
  assign ovr_ok = acc_ovr_en && (acc_ovr_seg < N_CODE);

  always_comb begin
    unique case (acc_kind_e'(acc_kind))
      ACC_FETCH: seg_id = CS_CODE;
      ACC_STACK: seg_id = SS_CODE;
      default:   seg_id = ovr_ok ? acc_ovr_seg : DS_CODE;
    endcase
  end

  assign seg_sel  = sel_q[seg_id];
  assign seg_base = base_q[seg_id];
endmodule

// File: rtl/seg_agu_stage.sv
module seg_agu_stage
  import seg_pkg::*;
#(
  parameter int SW = SEL_W,
  parameter int AW = ADDR_W,
  parameter int CW = SEG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic [AW-1:0] seg_base,
  input  logic [AW-1:0] acc_offset,
  input  logic [CW-1:0] seg_id,
  input  logic [SW-1:0] seg_sel,
  output logic          addr_valid,
  output logic [AW-1:0] addr_lin,
  output logic [CW-1:0] addr_seg,
  output logic [SW-1:0] addr_sel
);
  // Sum kept at AW bits: carry out is dropped, giving modulo 2^AW.
  logic [AW-1:0] sum;
  assign sum = seg_base + acc_offset;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_valid <= 1'b0;
      addr_lin   <= '0;
      addr_seg   <= '0;
      addr_sel   <= '0;
    end else begin
      addr_valid <= acc_valid;
      if (acc_valid) begin
        addr_lin <= sum;
        addr_seg <= seg_id;
        addr_sel <= seg_sel;
      end
    end
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [SEG_W-1:0]  ld_seg,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [ADDR_W-1:0] ld_base,
  input  logic              far_valid,
  input  logic [SEL_W-1:0]  far_sel,
  input  logic [ADDR_W-1:0] far_base,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic              acc_ovr_en,
  input  logic [SEG_W-1:0]  acc_ovr_seg,
  input  logic [ADDR_W-1:0] acc_offset,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr_lin,
  output logic [SEG_W-1:0]  addr_seg,
  output logic [SEL_W-1:0]  addr_sel,
  output logic              ld_err
);
  logic [NUM_SEG-1:0][SEL_W-1:0]  sel_q;
  logic [NUM_SEG-1:0][ADDR_W-1:0] base_q;
  logic [SEG_W-1:0]               seg_id;
  logic [SEL_W-1:0]               seg_sel;
  logic [ADDR_W-1:0]              seg_base;

  seg_bank #(
    .N  (NUM_SEG),
    .SW (SEL_W),
    .AW (ADDR_W),
    .CW (SEG_W)
  ) bank_i (
    .clk       (clk),
    .rst       (rst),
    .ld_valid  (ld_valid),
    .ld_seg    (ld_seg),
    .ld_sel    (ld_sel),
    .ld_base   (ld_base),
    .far_valid (far_valid),
    .far_sel   (far_sel),
    .far_base  (far_base),
    .sel_q     (sel_q),
    .base_q    (base_q),
    .ld_err    (ld_err)
  );

  seg_route #(
    .N  (NUM_SEG),
    .SW (SEL_W),
    .AW (ADDR_W),
    .CW (SEG_W)
  ) route_i (
    .acc_kind    (acc_kind),
    .acc_ovr_en  (acc_ovr_en),
    .acc_ovr_seg (acc_ovr_seg),
    .sel_q       (sel_q),
    .base_q      (base_q),
    .seg_id      (seg_id),
    .seg_sel     (seg_sel),
    .seg_base    (seg_base)
  );

  seg_agu_stage #(
    .SW (SEL_W),
    .AW (ADDR_W),
    .CW (SEG_W)
  ) stage_i (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .seg_base   (seg_base),
    .acc_offset (acc_offset),
    .seg_id     (seg_id),
    .seg_sel    (seg_sel),
    .addr_valid (addr_valid),
    .addr_lin   (addr_lin),
    .addr_seg   (addr_seg),
    .addr_sel   (addr_sel)
  );
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk
  import seg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ld_valid,
  input logic [SEG_W-1:0]  ld_seg,
  input logic              acc_valid,
  input logic [1:0]        acc_kind,
  input logic              acc_ovr_en,
  input logic [SEG_W-1:0]  acc_ovr_seg,
  input logic              addr_valid,
  input logic [SEG_W-1:0]  addr_seg,
  input logic              ld_err
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> addr_valid);

  assert_idle_clears_R2: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !addr_valid);

  assert_fetch_code_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == 2'd0) |=> (addr_seg == 3'd0));

  assert_stack_seg_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind == 2'd1) |=> (addr_seg == 3'd1));

  assert_data_default_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind[1] && !(acc_ovr_en && acc_ovr_seg < 3'd6))
      |=> (addr_seg == 3'd2));

  assert_data_override_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_kind[1] && acc_ovr_en && acc_ovr_seg < 3'd6)
      |=> (addr_seg == $past(acc_ovr_seg)));

  assert_reject_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && (ld_seg == 3'd0 || ld_seg > 3'd5)) |=> ld_err);

  assert_accept_noflag_R7: assert property (@(posedge clk) disable iff (rst)
    !(ld_valid && (ld_seg == 3'd0 || ld_seg > 3'd5)) |=> !ld_err);
endmodule

bind seg_addr_gen seg_addr_gen_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .ld_valid    (ld_valid),
  .ld_seg      (ld_seg),
  .acc_valid   (acc_valid),
  .acc_kind    (acc_kind),
  .acc_ovr_en  (acc_ovr_en),
  .acc_ovr_seg (acc_ovr_seg),
  .addr_valid  (addr_valid),
  .addr_seg    (addr_seg),
  .ld_err      (ld_err)
);

// File: tb/seg_addr_gen_tb_top.sv
module seg_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic [2:0]  ld_seg = '0;
  logic [15:0] ld_sel = '0;
  logic [31:0] ld_base = '0;
  logic        far_valid = 1'b0;
  logic [15:0] far_sel = '0;
  logic [31:0] far_base = '0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_kind = '0;
  logic        acc_ovr_en = 1'b0;
  logic [2:0]  acc_ovr_seg = '0;
  logic [31:0] acc_offset = '0;
  logic        addr_valid;
  logic [31:0] addr_lin;
  logic [2:0]  addr_seg;
  logic [15:0] addr_sel;
  logic        ld_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seg_addr_gen dut_i (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel), .ld_base(ld_base),
    .far_valid(far_valid), .far_sel(far_sel), .far_base(far_base),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_ovr_en(acc_ovr_en),
    .acc_ovr_seg(acc_ovr_seg), .acc_offset(acc_offset),
    .addr_valid(addr_valid), .addr_lin(addr_lin), .addr_seg(addr_seg),
    .addr_sel(addr_sel), .ld_err(ld_err)
  );

  // Fields: kind[72:71] ovr_en[70] ovr_seg[69:67] offset[66:35] exp_addr[34:3] exp_seg[2:0]
  localparam int NV = 12;
  localparam logic [72:0] VECS [NV] = '{
    {2'd0, 1'b0, 3'd0, 32'h0000_0100, 32'h0001_0100, 3'd0},
    {2'd1, 1'b0, 3'd0, 32'h0000_0FFC, 32'h0002_0FFC, 3'd1},
    {2'd2, 1'b0, 3'd0, 32'h0000_0010, 32'h0003_0010, 3'd2},
    {2'd2, 1'b1, 3'd3, 32'h0000_0020, 32'h0004_0020, 3'd3},
    {2'd2, 1'b1, 3'd4, 32'h0000_2000, 32'h0000_1000, 3'd4},
    {2'd3, 1'b1, 3'd5, 32'h0000_0000, 32'h0006_0000, 3'd5},
    {2'd2, 1'b1, 3'd0, 32'h0000_0004, 32'h0001_0004, 3'd0},
    {2'd2, 1'b1, 3'd1, 32'h0000_0008, 32'h0002_0008, 3'd1},
    {2'd2, 1'b1, 3'd6, 32'h0000_0005, 32'h0003_0005, 3'd2},
    {2'd0, 1'b1, 3'd3, 32'h0000_0200, 32'h0001_0200, 3'd0},
    {2'd1, 1'b1, 3'd5, 32'h0000_0004, 32'h0002_0004, 3'd1},
    {2'd3, 1'b1, 3'd7, 32'hFFFF_FFFF, 32'h0002_FFFF, 3'd2}
  };

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Advance to the next falling edge, then drop all request strobes.
  task automatic step();
    @(negedge clk);
    ld_valid = 1'b0;
    far_valid = 1'b0;
    acc_valid = 1'b0;
  endtask

  task automatic set_acc(input logic [1:0] k, input logic oe, input logic [2:0] os,
                         input logic [31:0] off);
    acc_valid = 1'b1; acc_kind = k; acc_ovr_en = oe; acc_ovr_seg = os; acc_offset = off;
  endtask

  task automatic set_ld(input logic [2:0] s, input logic [15:0] sel, input logic [31:0] b);
    ld_valid = 1'b1; ld_seg = s; ld_sel = sel; ld_base = b;
  endtask

  task automatic set_far(input logic [15:0] sel, input logic [31:0] b);
    far_valid = 1'b1; far_sel = sel; far_base = b;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid low in reset", {31'd0, addr_valid}, 32'd0);
    chk("R1 ld_err low in reset", {31'd0, ld_err}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid low after reset", {31'd0, addr_valid}, 32'd0);

    // Zero bases after reset
    set_acc(2'd0, 1'b0, 3'd0, 32'h0000_1234); step();
    chk("R1 zero base addr", addr_lin, 32'h0000_1234);
    chk("R1 zero selector", {16'd0, addr_sel}, 32'd0);
    chk("R2 valid after access", {31'd0, addr_valid}, 32'd1);
    step();
    chk("R2 valid low when idle", {31'd0, addr_valid}, 32'd0);

    // Rejected loads
    set_ld(3'd0, 16'hBEEF, 32'h5000_0000); step();
    chk("R7 code load flagged", {31'd0, ld_err}, 32'd1);
    set_acc(2'd0, 1'b0, 3'd0, 32'h0000_0010); step();
    chk("R7 ld_err one cycle", {31'd0, ld_err}, 32'd0);
    chk("R7 code base unchanged", addr_lin, 32'h0000_0010);
    chk("R7 code sel unchanged", {16'd0, addr_sel}, 32'd0);
    set_ld(3'd6, 16'h1111, 32'h2222_0000); step();
    chk("R7 code 6 flagged", {31'd0, ld_err}, 32'd1);
    set_acc(2'd2, 1'b0, 3'd0, 32'h0000_0040); step();
    chk("R7 code 6 no data change", addr_lin, 32'h0000_0040);

    // Populate segments
    set_far(16'h0008, 32'h0001_0000); step();
    for (int s = 1; s < 6; s++) begin
      logic [31:0] b;
      b = (s == 4) ? 32'hFFFF_F000 : (32'(s + 1) << 16);
      set_ld(3'(s), 16'((s + 1) * 8), b); step();
      chk("R7 good load not flagged", {31'd0, ld_err}, 32'd0);
    end

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      logic [72:0] v;
      v = VECS[i];
      set_acc(v[72:71], v[70], v[69:67], v[66:35]); step();
      chk($sformatf("R2 vec %0d addr", i), addr_lin, v[34:3]);
      chk($sformatf("R3 R4 R5 vec %0d seg", i), {29'd0, addr_seg}, {29'd0, v[2:0]});
      chk($sformatf("R9 vec %0d sel", i), {16'd0, addr_sel}, 32'((32'(v[2:0]) + 1) * 8));
    end

    // Load and access in the same cycle
    set_ld(3'd2, 16'h0038, 32'h0007_0000);
    set_acc(2'd2, 1'b0, 3'd0, 32'h0000_0000); step();
    chk("R6 same-cycle sees old base", addr_lin, 32'h0003_0000);
    chk("R6 same-cycle sees old sel", {16'd0, addr_sel}, 32'h0000_0018);
    set_acc(2'd2, 1'b0, 3'd0, 32'h0000_0000); step();
    chk("R6 next access sees new base", addr_lin, 32'h0007_0000);
    chk("R6 next access sees new sel", {16'd0, addr_sel}, 32'h0000_0038);

    // Far transfer with fetch in the same cycle
    set_far(16'h0048, 32'h0009_0000);
    set_acc(2'd0, 1'b0, 3'd0, 32'h0000_0004); step();
    chk("R8 same-cycle fetch old", addr_lin, 32'h0001_0004);
    set_acc(2'd0, 1'b0, 3'd0, 32'h0000_0004); step();
    chk("R8 fetch new code base", addr_lin, 32'h0009_0004);
    chk("R8 new code sel", {16'd0, addr_sel}, 32'h0000_0048);

    // Reset clears loaded state
    rst = 1'b1; step(); step();
    rst = 1'b0; step();
    set_acc(2'd1, 1'b0, 3'd0, 32'h0000_0ABC); step();
    chk("R1 stack base cleared", addr_lin, 32'h0000_0ABC);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule